// File: doc/BRIEF.md
# Hardwired Instruction Cycle Controller

This block is a hardwired control unit joined to a small single-accumulator datapath. A two-bit phase register selects one of four phases: fetch, indirect, execute or interrupt. A slot counter splits each phase into three timing slots, t1 to t3. In every slot the control logic combines the slot line with the phase and a one-hot decode of the opcode. The result is a fixed set of register transfers among the address register, the buffer register, the program counter, the instruction register and the accumulator.

Memory sits outside the block on a simple port. The block presents an address, a read strobe, a write strobe and write data. Read data must be valid during the cycle in which the read strobe is high. A write is captured at the clock edge that ends its strobe cycle. The address register always drives the address lines, so it is loaded one slot before any access that uses it.

An instruction word is DW bits wide. The opcode is in the top OPW bits, the indirect flag is at bit AW, and the address is in the low AW bits, where AW = DW-OPW-1.

Top module: `insn_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the block shows phase 00, slot t1, no read, no write, no acknowledge and no halt. The first word it fetches is taken from address 0.
- R2: The phase output reads 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt. The slot output is one-hot, with bit 0 for t1, bit 1 for t2 and bit 2 for t3. Every phase lasts exactly three slots, and the slot returns to t1 whenever the phase changes.
- R3: In fetch, t1 loads the address register from the program counter. In t2 the block reads memory at that address into the buffer register and increments the program counter modulo 2^AW. In t3 the word moves into the instruction register. The next phase is indirect if bit AW of the word is 1, and execute if it is 0.
- R4: In indirect, the block reads memory in t2 at the instruction's address field. In t3 it replaces that field with the low AW bits of the word it read, and the next phase is execute.
- R5: LOAD (opcode 1) and ADD (opcode 3) read memory in execute t2 at the address field. In t3, LOAD puts the word it read into the accumulator, and ADD puts the accumulator plus that word, modulo 2^DW, into the accumulator.
- R6: STORE (opcode 2) writes the accumulator to the address field with exactly one write strobe, in execute t2.
- R7: Opcode 4 sets the interrupt enable, and reset clears it. At the end of execute, if the enable is set and the request input is high, the next phase is interrupt. The acknowledge output is then high for exactly the t1 cycle of that phase, and the enable is cleared.
- R8: In interrupt t3, the block writes the program counter value of the interrupted program to SAVE_ADDR. The next phase is fetch, starting at HANDLER_ADDR.
- R9: While the enable is clear, the request input is ignored, and execute is always followed by fetch.
- R10: HALT (opcode 7) raises the halted output in execute t1. From then until reset, the phase holds and no read, write or acknowledge occurs.
- R11: Opcodes 0, 5 and 6 perform no memory access and leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | AW | Memory address, driven from the address register |
| mem_rdata | input | DW | Memory read data, valid while mem_rd is high |
| mem_wdata | output | DW | Memory write data, driven from the buffer register |
| mem_rd | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| irq | input | 1 | Interrupt request level |
| irq_ack | output | 1 | Interrupt acknowledge pulse |
| phase | output | 2 | Current phase code |
| slot | output | 3 | One-hot timing slot |
| halted | output | 1 | High once HALT has executed |

## Verification
The bench builds the block with DW=12 and OPW=3. This gives an 8-bit address field and a 256-word memory model that holds the programs, their operands, the save location 0xF0 and the handler at 0x40. With a 12-bit word, an ADD of 0xFFF and 0x002 carries out of the top bit, which makes accumulator wraparound easy to observe. An indirect pointer word 0xFA0 carries nonzero upper bits, which shows that only its address field is taken.

// File: rtl/insn_cycle_ctrl.sv
module insn_cycle_ctrl #(
  parameter int DW = 16,
  parameter int OPW = 3,
  parameter logic [DW-OPW-2:0] SAVE_ADDR = '1,
  parameter logic [DW-OPW-2:0] HANDLER_ADDR = 'd2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [DW-OPW-2:0]    mem_addr,
  input  logic [DW-1:0]        mem_rdata,
  output logic [DW-1:0]        mem_wdata,
  output logic                 mem_rd,
  output logic                 mem_we,
  input  logic                 irq,
  output logic                 irq_ack,
  output logic [1:0]           phase,
  output logic [2:0]           slot,
  output logic                 halted
);
  localparam int AW = DW - OPW - 1;
  localparam int NOPS = 1 << OPW;
  localparam logic [1:0] PH_FET = 2'b00, PH_IND = 2'b01, PH_EXE = 2'b10, PH_INT = 2'b11;
  localparam int OP_LOAD = 1, OP_STORE = 2, OP_ADD = 3, OP_EINT = 4, OP_HALT = 7;

  logic [1:0]    ph, ts;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mbr, ir, acc;
  logic          ien, hlt;
  logic [NOPS-1:0] dec;
  logic          t1, t2, t3;
  logic          unused_bits;

  assign t1 = (ts == 2'd0);
  assign t2 = (ts == 2'd1);
  assign t3 = (ts == 2'd2);
  assign dec = NOPS'(1) << ir[DW-1 -: OPW];
  assign unused_bits = ^{ir[AW], dec};

  wire is_ld  = dec[OP_LOAD];
  wire is_st  = dec[OP_STORE];
  wire is_add = dec[OP_ADD];
  wire in_exe = (ph == PH_EXE);
  wire take_int = ien && irq;

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd  = !hlt && t2 && (ph == PH_FET || ph == PH_IND || (in_exe && (is_ld || is_add)));
  assign mem_we  = !hlt && ((in_exe && t2 && is_st) || (ph == PH_INT && t3));
  assign irq_ack = !hlt && (ph == PH_INT) && t1;
  assign phase   = ph;
  assign slot    = {t3, t2, t1};
  assign halted  = hlt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_FET;
      ts  <= 2'd0;
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
      ien <= 1'b0;
      hlt <= 1'b0;
    end else if (!hlt) begin
      ts <= t3 ? 2'd0 : ts + 2'd1;
      case (ph)
        PH_FET: begin
          if (t1) mar <= pc;
          if (t2) begin
            mbr <= mem_rdata;
            pc  <= pc + 1'b1;
          end
          if (t3) begin
            ir <= mbr;
            ph <= mbr[AW] ? PH_IND : PH_EXE;
          end
        end
        PH_IND: begin
          if (t1) mar <= ir[AW-1:0];
          if (t2) mbr <= mem_rdata;
          if (t3) begin
            ir[AW-1:0] <= mbr[AW-1:0];
            ph <= PH_EXE;
          end
        end
        PH_EXE: begin
          if (t1) begin
            if (is_ld || is_add || is_st) mar <= ir[AW-1:0];
            if (is_st) mbr <= acc;
            if (dec[OP_EINT]) ien <= 1'b1;
            if (dec[OP_HALT]) hlt <= 1'b1;
          end
          if (t2 && (is_ld || is_add)) mbr <= mem_rdata;
          if (t3) begin
            if (is_ld) acc <= mbr;
            if (is_add) acc <= acc + mbr;
            ph <= take_int ? PH_INT : PH_FET;
            if (take_int) ien <= 1'b0;
          end
        end
        default: begin
          if (t1) mbr <= {{(DW-AW){1'b0}}, pc};
          if (t2) begin
            mar <= SAVE_ADDR;
            pc  <= HANDLER_ADDR;
          end
          if (t3) ph <= PH_FET;
        end
      endcase
    end
  end
endmodule

// File: rtl/insn_cycle_ctrl_chk.sv
module insn_cycle_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase,
  input logic [2:0] slot,
  input logic       mem_rd,
  input logic       mem_we,
  input logic       irq_ack,
  input logic       halted
);
  p_slot_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot) == 1);

  p_phase_change_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> slot == 3'b001);

  p_fetch_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && slot == 3'b010) |-> mem_rd);

  p_no_rd_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  p_ack_at_int_t1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (phase == 2'b11 && slot == 3'b001));

  p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  p_int_after_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11 && slot == 3'b001) |-> $past(phase) == 2'b10);

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(phase)));

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(mem_rd || mem_we || irq_ack));
endmodule

bind insn_cycle_ctrl insn_cycle_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .slot(slot),
  .mem_rd(mem_rd), .mem_we(mem_we), .irq_ack(irq_ack), .halted(halted)
);

// File: tb/insn_cycle_ctrl_tb.sv
module insn_cycle_ctrl_tb;
  localparam int DW = 12;
  localparam int OPW = 3;
  localparam int AW = DW - OPW - 1;
  localparam logic [AW-1:0] SAVE = 8'hF0;
  localparam logic [AW-1:0] HAND = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, mem_wdata;
  logic mem_rd, mem_we, irq_ack, halted;
  logic [1:0] phase;
  logic [2:0] slot;
  logic [DW-1:0] mem [256];

  int n_chk = 0, n_fail = 0, n_rd = 0, n_we = 0, n_ack = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  insn_cycle_ctrl #(.DW(DW), .OPW(OPW), .SAVE_ADDR(SAVE), .HANDLER_ADDR(HAND)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_we(mem_we), .irq(irq),
    .irq_ack(irq_ack), .phase(phase), .slot(slot), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [DW-1:0] enc(input int op, input bit ind, input int a);
    logic [2:0] o = op[2:0];
    logic [7:0] ad = a[7:0];
    return {o, ind, ad};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (mem_rd) n_rd++;
    if (mem_we) n_we++;
    if (irq_ack) n_ack++;
  endtask

  task automatic boot();
    @(negedge clk);
    rst_n = 1'b0;
    irq = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    n_rd = 0; n_we = 0; n_ack = 0;
    @(negedge clk);
  endtask

  task automatic go();
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt();
    for (int i = 0; i < 200 && !halted; i++) step();
  endtask

  task automatic t_load_add_store();
    boot();
    chk("R1 reset phase", phase, 2'b00);
    chk("R1 reset strobes", {mem_rd, mem_we, irq_ack, halted}, 4'b0000);
    mem[0] = enc(1, 0, 'h20);
    mem[1] = enc(3, 0, 'h21);
    mem[2] = enc(2, 0, 'h30);
    mem[3] = enc(7, 0, 0);
    mem['h20] = 12'h123;
    mem['h21] = 12'h045;
    go();
    chk("R1 first cycle fetch t1", {phase, slot, mem_rd}, {2'b00, 3'b001, 1'b0});
    step();
    chk("R3 fetch t2 reads addr 0", {phase, slot, mem_rd, mem_addr}, {2'b00, 3'b010, 1'b1, 8'h00});
    step();
    chk("R2 fetch t3", {phase, slot, mem_rd}, {2'b00, 3'b100, 1'b0});
    step();
    chk("R3 direct goes to execute", {phase, slot}, {2'b10, 3'b001});
    step();
    chk("R5 load reads operand in t2", {phase, slot, mem_rd, mem_addr}, {2'b10, 3'b010, 1'b1, 8'h20});
    step();
    chk("R2 execute t3", slot, 3'b100);
    step();
    chk("R9 execute to fetch without enable", {phase, slot, mem_rd}, {2'b00, 3'b001, 1'b0});
    step();
    chk("R3 pc incremented", mem_addr, 8'h01);
    run_to_halt();
    chk("R5 R6 load plus add stored", mem['h30], 12'h168);
    chk("R6 single write strobe", n_we, 1);
    chk("R10 halted in execute", {halted, phase}, {1'b1, 2'b10});
    n_rd = 0; n_we = 0;
    for (int i = 0; i < 12; i++) step();
    chk("R10 no activity after halt", {n_rd, n_we}, 64'd0);
    chk("R10 phase held", phase, 2'b10);
  endtask

  task automatic t_indirect();
    boot();
    mem[0] = enc(1, 1, 'h50);
    mem[1] = enc(2, 0, 'h31);
    mem[2] = enc(7, 0, 0);
    mem['h50] = 12'hFA0;
    mem['hA0] = 12'h777;
    go();
    repeat (3) step();
    chk("R4 indirect bit selects indirect", {phase, slot}, {2'b01, 3'b001});
    step();
    chk("R4 pointer read at field", {mem_rd, mem_addr}, {1'b1, 8'h50});
    repeat (2) step();
    chk("R4 indirect then execute", {phase, slot}, {2'b10, 3'b001});
    step();
    chk("R4 operand at replaced field", {mem_rd, mem_addr}, {1'b1, 8'hA0});
    run_to_halt();
    chk("R4 indirect load result", mem['h31], 12'h777);
  endtask

  task automatic t_wrap_and_noops();
    boot();
    mem[0] = enc(1, 0, 'h20);
    mem[1] = enc(5, 0, 'h30);
    mem[2] = enc(3, 0, 'h21);
    mem[3] = enc(6, 0, 'h30);
    mem[4] = enc(2, 0, 'h30);
    mem[5] = enc(0, 0, 'h30);
    mem[6] = enc(7, 0, 0);
    mem['h20] = 12'hFFF;
    mem['h21] = 12'h002;
    mem['h30] = 12'h555;
    go();
    run_to_halt();
    chk("R5 add wraps modulo 2^DW", mem['h30], 12'h001);
    chk("R11 reads only fetches and two operands", n_rd, 9);
    chk("R11 only the store writes", n_we, 1);
  endtask

  task automatic t_interrupt();
    boot();
    mem[0] = enc(0, 0, 0);
    mem[1] = enc(4, 0, 0);
    mem[2] = enc(7, 0, 0);
    mem['h40] = enc(7, 0, 0);
    irq = 1'b1;
    go();
    repeat (6) step();
    chk("R9 request ignored while disabled", {phase, slot, n_ack[0]}, {2'b00, 3'b001, 1'b0});
    repeat (6) step();
    chk("R7 enter interrupt with ack", {phase, slot, irq_ack}, {2'b11, 3'b001, 1'b1});
    step();
    chk("R7 ack one cycle", {slot, irq_ack}, {3'b010, 1'b0});
    step();
    chk("R8 save write", {mem_we, mem_addr, mem_wdata}, {1'b1, SAVE, 12'h002});
    step();
    chk("R8 back to fetch", {phase, slot}, {2'b00, 3'b001});
    step();
    chk("R8 fetch from handler", {mem_rd, mem_addr}, {1'b1, HAND});
    run_to_halt();
    chk("R8 saved pc in memory", mem[SAVE], 12'h002);
    chk("R7 enable cleared so one ack", n_ack, 1);
    chk("R10 handler halt", halted, 1'b1);
  endtask

  initial begin
    t_load_add_store();
    t_indirect();
    t_wrap_and_noops();
    t_interrupt();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule